// File: doc/BRIEF.md
# Receive Pattern Sync and Alarm Monitor

This block watches the received serial stream of a bit error rate tester. On every cycle where `rx_valid` is high it takes one received bit and the bit a local pattern generator expects at that position. It flags long runs of identical received bits, decides whether the receiver is aligned to the expected pattern, and marks every mismatched bit while aligned. It also keeps the most recent 32 received bits in a capture word that a host can read one byte at a time.

Alignment is kept by a two-state machine. `ST_HUNT` is entered at reset and while searching. Transition *hunt-to-locked* fires on the 32nd consecutive matching valid bit. `ST_LOCKED` is the aligned state. Transition *locked-to-hunt (density)* fires when 6 or more of the most recent 64 valid bits since lock were in error, and only while `hold_mode` is 0. Transition *any-to-hunt (resync)* fires on `resync_req` from either state.

The error window is a 64-entry history shift register. A running count of its ones is updated by adding the newest error and removing the oldest, so the threshold compare never needs a full population count.

Top module: `rx_sync_monitor`

## Requirements
- R1: While reset is active and on the first cycle after it, `searching` is 1 and `in_sync`, `all_ones`, `all_zeros` and `bit_err` are 0. `pat_word` is 0 and the match count and error history are empty.
- R2: `all_ones` rises in the cycle after the 32nd consecutive valid received 1. It falls in the cycle after a valid received 0.
- R3: `all_zeros` rises in the cycle after the 32nd consecutive valid received 0. It falls in the cycle after a valid received 1.
- R4: In `ST_HUNT` a valid bit with `rx_bit == exp_bit` advances a match count and a valid mismatch restarts it. The 32nd consecutive match moves to `ST_LOCKED`, so in the next cycle `in_sync` is 1 and `searching` is 0. The two outputs are always complementary.
- R5: `bit_err` is 1 for exactly the cycle after each valid mismatched bit received in `ST_LOCKED`. It is never 1 after a bit received in `ST_HUNT`.
- R6: With `hold_mode` = 0, the valid bit that brings the errors among the last 64 valid bits since lock to 6 or more returns the block to `ST_HUNT` in the next cycle.
- R7: With `hold_mode` = 1, errors never cause loss of sync.
- R8: `resync_req` high at a clock edge moves the block to `ST_HUNT` from either state and clears the match count.
- R9: Each valid bit shifts into `pat_word` at bit 0, and the oldest of the last 32 bits sits at bit 31.
- R10: `rd_data` is combinational. Address 0x10 returns `pat_word[31:24]`, 0x11 returns [23:16], 0x12 returns [15:8], 0x13 returns [7:0], and any other address returns 0x00.
- R11: A cycle with `rx_valid` = 0 changes neither the run detectors, the match count, the error window nor `pat_word`, and produces no `bit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Qualifies `rx_bit` and `exp_bit` for this cycle |
| rx_bit | input | 1 | Received data bit |
| exp_bit | input | 1 | Locally generated expected bit |
| hold_mode | input | 1 | 1 disables the error-density loss rule |
| resync_req | input | 1 | Forces a return to hunting |
| rd_addr | input | 8 | Byte address of the capture word |
| rd_data | output | 8 | Selected capture byte |
| pat_word | output | 32 | Last 32 received bits, newest at bit 0 |
| all_ones | output | 1 | All-ones run condition |
| all_zeros | output | 1 | All-zeros run condition |
| in_sync | output | 1 | Live alignment status |
| searching | output | 1 | Hunting for alignment |
| bit_err | output | 1 | One-cycle pulse per mismatched bit while aligned |

## Verification
The assertions check several properties on every cycle. The error count must equal the population of the history register and never exceed 64. `bit_err` may only follow a cycle spent locked. Run flags may rise only after a valid bit of their polarity. A resync request must always lead to hunting, and hold mode must keep sync. Idle cycles must leave the capture word alone. Exact cycle counts are shown only by the bench's scenarios: lock on the 32nd match, loss on the 6th error inside the window but not when errors fall outside it, and the flag edges after 32 identical bits.

// File: rtl/rx_mon_pkg.sv
package rx_mon_pkg;

    typedef enum logic [0:0] {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } sync_state_e;

    localparam int RUN_LEN_DEF  = 32;
    localparam int SYNC_LEN_DEF = 32;
    localparam int WIN_LEN_DEF  = 64;
    localparam int LOSS_THR_DEF = 6;
    localparam int PAT_W_DEF    = 32;

endpackage

// File: rtl/rx_run_detect.sv
module rx_run_detect #(
    parameter int   RUN_LEN  = 32,
    parameter logic POLARITY = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic din,
    output logic run_flag
);
    localparam int CW = $clog2(RUN_LEN + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (step) begin
            if (din == POLARITY) begin
                if (run_cnt != CW'(RUN_LEN))
                    run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
        end
    end

    assign run_flag = (run_cnt == CW'(RUN_LEN));

    // R2 R3
    run_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_flag) |-> $past(step && (din == POLARITY)));

    // R11
    run_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) |-> $stable(run_cnt));

endmodule

// File: rtl/rx_err_window.sv
module rx_err_window #(
    parameter int WIN_LEN  = 64,
    parameter int LOSS_THR = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic err_in,
    output logic loss_hit
);
    localparam int CW = $clog2(WIN_LEN + 1);

    logic [WIN_LEN-1:0] hist;
    logic [CW-1:0]      err_cnt;
    logic [CW-1:0]      cnt_next;

    always_comb begin
        cnt_next = err_cnt + CW'(err_in) - CW'(hist[WIN_LEN-1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist    <= '0;
            err_cnt <= '0;
        end else if (clear) begin
            hist    <= '0;
            err_cnt <= '0;
        end else if (step) begin
            hist    <= {hist[WIN_LEN-2:0], err_in};
            err_cnt <= cnt_next;
        end
    end

    assign loss_hit = step && !clear && (cnt_next >= CW'(LOSS_THR));

    // R6
    win_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt == CW'($countones(hist)));

    // R6
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= CW'(WIN_LEN));

endmodule

// File: rtl/rx_sync_fsm.sv
module rx_sync_fsm
    import rx_mon_pkg::*;
#(
    parameter int SYNC_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic bit_match,
    input  logic loss_hit,
    input  logic hold_mode,
    input  logic resync_req,
    output logic locked,
    output logic bit_err
);
    localparam int MW = $clog2(SYNC_LEN + 1);

    sync_state_e   state_q, state_d;
    logic [MW-1:0] match_q, match_d;
    logic          err_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            match_q <= '0;
            bit_err <= 1'b0;
        end else begin
            state_q <= state_d;
            match_q <= match_d;
            bit_err <= err_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        match_d = match_q;
        err_d   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (resync_req) begin
                    match_d = '0;
                end else if (step) begin
                    if (!bit_match) begin
                        match_d = '0;
                    end else if (match_q == MW'(SYNC_LEN - 1)) begin
                        match_d = '0;
                        state_d = ST_LOCKED;
                    end else begin
                        match_d = match_q + 1'b1;
                    end
                end
            end
            ST_LOCKED: begin
                match_d = '0;
                err_d   = step && !bit_match;
                if (resync_req)
                    state_d = ST_HUNT;
                else if (loss_hit && !hold_mode)
                    state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    assign locked = (state_q == ST_LOCKED);

    // R5
    err_only_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err |-> $past(locked));

    // R7
    hold_keeps_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && hold_mode && !resync_req) |=> locked);

    // R8
    resync_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync_req |=> !locked);

    // R4
    lock_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(step && bit_match));

endmodule

// File: rtl/rx_pattern_capture.sv
module rx_pattern_capture #(
    parameter int          PAT_W     = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              din,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [PAT_W-1:0]  pat_q
);
    localparam int NBYTES = PAT_W / 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pat_q <= '0;
        else if (step)
            pat_q <= {pat_q[PAT_W-2:0], din};
    end

    // byte 0 of the map holds the oldest bits
    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_addr == ADDR_W'(int'(BASE_ADDR) + i))
                rd_data = pat_q[(NBYTES - 1 - i) * 8 +: 8];
        end
    end

    // R11
    pat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(step) |-> $stable(pat_q));

    // R9
    pat_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (pat_q[0] == $past(din)));

endmodule

// File: rtl/rx_sync_monitor.sv
module rx_sync_monitor
    import rx_mon_pkg::*;
#(
    parameter int RUN_LEN  = RUN_LEN_DEF,
    parameter int SYNC_LEN = SYNC_LEN_DEF,
    parameter int WIN_LEN  = WIN_LEN_DEF,
    parameter int LOSS_THR = LOSS_THR_DEF,
    parameter int PAT_W    = PAT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_bit,
    input  logic             exp_bit,
    input  logic             hold_mode,
    input  logic             resync_req,
    input  logic [7:0]       rd_addr,
    output logic [7:0]       rd_data,
    output logic [PAT_W-1:0] pat_word,
    output logic             all_ones,
    output logic             all_zeros,
    output logic             in_sync,
    output logic             searching,
    output logic             bit_err
);
    logic locked;
    logic loss_hit;
    logic bit_match;
    logic [1:0] run_flags;

    assign bit_match = (rx_bit == exp_bit);

    for (genvar g = 0; g < 2; g++) begin : g_run
        rx_run_detect #(
            .RUN_LEN  (RUN_LEN),
            .POLARITY ((g == 0) ? 1'b1 : 1'b0)
        ) u_run (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (rx_valid),
            .din      (rx_bit),
            .run_flag (run_flags[g])
        );
    end

    assign all_ones  = run_flags[0];
    assign all_zeros = run_flags[1];

    rx_err_window #(
        .WIN_LEN  (WIN_LEN),
        .LOSS_THR (LOSS_THR)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!locked),
        .step     (rx_valid && locked),
        .err_in   (!bit_match),
        .loss_hit (loss_hit)
    );

    rx_sync_fsm #(
        .SYNC_LEN (SYNC_LEN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (rx_valid),
        .bit_match  (bit_match),
        .loss_hit   (loss_hit),
        .hold_mode  (hold_mode),
        .resync_req (resync_req),
        .locked     (locked),
        .bit_err    (bit_err)
    );

    rx_pattern_capture #(
        .PAT_W     (PAT_W),
        .ADDR_W    (8),
        .BASE_ADDR (8'h10)
    ) u_pat (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (rx_valid),
        .din     (rx_bit),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pat_q   (pat_word)
    );

    assign in_sync   = locked;
    assign searching = !locked;

    // R2 R3
    run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_ones && all_zeros));

    // R6
    density_loss_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_sync) |-> $past(resync_req || (!hold_mode && rx_valid && !bit_match)));

endmodule

// File: tb/rx_sync_monitor_bench.sv
module rx_sync_monitor_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 1'b0, rx_bit = 1'b0, exp_bit = 1'b0;
    logic hold_mode = 1'b0, resync_req = 1'b0;
    logic [7:0] rd_addr = 8'h10;
    logic [7:0] rd_data;
    logic [31:0] pat_word;
    logic all_ones, all_zeros, in_sync, searching, bit_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_sync_monitor u_rx_sync_monitor (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .exp_bit(exp_bit), .hold_mode(hold_mode), .resync_req(resync_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .pat_word(pat_word),
        .all_ones(all_ones), .all_zeros(all_zeros), .in_sync(in_sync),
        .searching(searching), .bit_err(bit_err)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int ones_run = 0, zeros_run = 0, match_run = 0;
    bit m_lock = 0, m_err = 0, last_v = 1;
    bit win_q[$];
    logic [31:0] m_pat = '0, prev_pat = '0;
    string sync_tag = "R4";
    int losses = 0, locks = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a, input logic [31:0] p);
        case (a)
            8'h10: return p[31:24];
            8'h11: return p[23:16];
            8'h12: return p[15:8];
            8'h13: return p[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        chk(all_ones == (ones_run >= 32), "R2", "all_ones", 32'(all_ones), 32'(ones_run >= 32));
        chk(all_zeros == (zeros_run >= 32), "R3", "all_zeros", 32'(all_zeros), 32'(zeros_run >= 32));
        chk(in_sync == m_lock, sync_tag, "in_sync", 32'(in_sync), 32'(m_lock));
        chk(searching == !m_lock, "R4", "searching", 32'(searching), 32'(!m_lock));
        chk(bit_err == m_err, "R5", "bit_err", 32'(bit_err), 32'(m_err));
        chk(pat_word == m_pat, "R9", "pat_word", pat_word, m_pat);
        chk(rd_data == exp_byte(rd_addr, m_pat), "R10", "rd_data", 32'(rd_data),
            32'(exp_byte(rd_addr, m_pat)));
        if (!last_v) begin
            chk(pat_word == prev_pat && !bit_err, "R11", "idle pattern", pat_word, prev_pat);
        end
    endtask

    function automatic int win_sum();
        int s = 0;
        foreach (win_q[i]) s += win_q[i];
        return s;
    endfunction

    task automatic model_step(input bit v, input bit b, input bit e, input bit hold, input bit rsq);
        bit was = m_lock;
        prev_pat = m_pat;
        last_v = v;
        m_err = v && m_lock && (b != e);
        if (v) begin
            if (b) begin ones_run = (ones_run < 32) ? ones_run + 1 : 32; zeros_run = 0; end
            else   begin zeros_run = (zeros_run < 32) ? zeros_run + 1 : 32; ones_run = 0; end
            m_pat = {m_pat[30:0], b};
        end
        if (m_lock && v) begin
            win_q.push_back(b != e);
            if (win_q.size() > 64) void'(win_q.pop_front());
        end
        if (rsq) begin
            m_lock = 0; match_run = 0; win_q.delete();
        end else if (!m_lock) begin
            if (v) begin
                if (b == e) match_run++; else match_run = 0;
                if (match_run >= 32) begin m_lock = 1; match_run = 0; win_q.delete(); end
            end
        end else if (v && !hold && win_sum() >= 6) begin
            m_lock = 0; match_run = 0; win_q.delete();
        end
        if (!was && m_lock) locks++;
        if (was && !m_lock && !rsq) losses++;
    endtask

    // one cycle: check the state produced by the last edge, then drive the next inputs
    task automatic cyc(input bit v, input bit b, input bit e, input bit rsq = 0);
        @(negedge clk);
        compare_all();
        rx_valid = v; rx_bit = b; exp_bit = e; resync_req = rsq;
        rd_addr = 8'h0F + 8'($urandom_range(0, 5));
        model_step(v, b, e, hold_mode, rsq);
    endtask

    task automatic run(input int n, input bit val, input bit err);
        for (int i = 0; i < n; i++) cyc(1, val, val ^ err);
    endtask

    task automatic rand_bits(input int n, input int err_mod, input int idle_mod);
        for (int i = 0; i < n; i++) begin
            bit b = 1'($urandom());
            bit v = ($urandom_range(0, idle_mod - 1) != 0);
            bit x = ($urandom_range(0, err_mod - 1) == 0);
            cyc(v, b, b ^ x);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(searching && !in_sync && !all_ones && !all_zeros && !bit_err && pat_word == 0,
            "R1", "reset state", {27'd0, searching, in_sync, all_ones, all_zeros, bit_err}, 32'h10);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 R2 R3 R4: runs of identical matched bits, lock on 32nd
        run(31, 1'b1, 1'b0);
        cyc(0, 1'b0, 1'b0);           // R11 idle 0 must not break the ones run
        run(9, 1'b1, 1'b0);
        run(1, 1'b0, 1'b0);
        run(40, 1'b0, 1'b0);
        run(1, 1'b1, 1'b0);
        // R5 R6: 5 spaced errors keep sync, 6th within 64 loses it
        sync_tag = "R6";
        for (int k = 0; k < 6; k++) begin
            run(1, 1'b1, 1'b1);
            run(9, 1'b0, 1'b0);
        end
        run(40, 1'b1, 1'b0);          // relock
        // R6: errors 70 bits apart never reach six in a window
        for (int k = 0; k < 8; k++) begin
            run(1, 1'b0, 1'b1);
            run(69, 1'b1, 1'b0);
        end
        chk(in_sync == 1'b1, "R6", "sparse errors keep sync", 32'(in_sync), 32'd1);
        // R7: hold mode ignores dense errors
        sync_tag = "R7";
        hold_mode = 1'b1;
        run(20, 1'b1, 1'b1);
        chk(in_sync == 1'b1, "R7", "hold keeps sync", 32'(in_sync), 32'd1);
        // R8: resync request
        sync_tag = "R8";
        cyc(1, 1'b1, 1'b1, 1'b1);
        run(20, 1'b0, 1'b0);
        cyc(1, 1'b0, 1'b0, 1'b1);     // clears match count during hunt
        run(31, 1'b0, 1'b0);
        chk(searching == 1'b1, "R8", "match count restarted", 32'(searching), 32'd1);
        run(2, 1'b1, 1'b0);
        hold_mode = 1'b0;
        // R4: mismatch during hunt restarts count
        sync_tag = "R4";
        cyc(1, 1'b1, 1'b1, 1'b1);
        run(30, 1'b1, 1'b0);
        run(1, 1'b1, 1'b1);
        run(31, 1'b0, 1'b0);
        chk(searching == 1'b1, "R4", "mismatch restarts hunt", 32'(searching), 32'd1);
        run(1, 1'b0, 1'b0);
        // mixed random traffic with idle cycles (R5 R6 R9 R10 R11)
        sync_tag = "R6";
        rand_bits(3000, 40, 4);
        rand_bits(3000, 12, 3);
        rand_bits(2000, 200, 2);
        cyc(0, 1'b0, 1'b0);
        chk(locks > 3 && losses > 1, "R6", "lock/loss episodes", 32'(losses), 32'd2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule